// File: doc/BRIEF.md
# Inter-Event Interval Trigger Engine

This block decides when a capture event should fire. Its inputs are single-cycle event flags (A and B) and trigger flags (trigger1 and trigger2), a 5-bit mode code and one threshold T. It produces a one-cycle `fire` pulse. Depending on the mode it can fire directly on trigger1. It can also time the gap between an A and the B that follows it, against T, using either the newest A or the oldest A that is still open. Other modes count trigger1 occurrences up to T, or fire when trigger1 is not followed by trigger2 within T cycles.

Alongside the trigger decision, the engine keeps the largest interval it has measured in the interval modes. When the select bit is set it keeps the smallest interval instead. Software reads this value as `extreme`. Pulling `en` low clears all measurement state and the extreme value. Mode or threshold changes are expected to go through a disable cycle.

Top module: `ivl_engine`

## Requirements
- R1: After reset, and one clock after any cycle with `en` low, `fire` is 0, `extreme` is 0, and no open interval, count or window survives into the next enabled period.
- R2: Mode 0: `fire` is 1 one clock after every enabled cycle in which `trg1` is 1.
- R3: Mode 1 measures from the most recent A to the next B and fires one clock after the B cycle when the interval is strictly greater than T. A new A while a measurement is open restarts it.
- R4: Mode 2 measures like mode 1 and fires when the interval is strictly less than T.
- R5: Modes 3 (greater than T) and 4 (less than T) measure from the first A of an open measurement. Later A pulses before the B are ignored.
- R6: The interval is the cycle index of B minus that of its A (minimum 1). An interval equal to T fires in none of modes 1 to 4. A B with no open measurement is ignored.
- R7: When A and B fall in the same cycle of an open measurement, B closes the old interval and A opens a new one from that cycle.
- R8: Mode 5 fires one clock after the cycle carrying the T-th `trg1` since enable or since the previous fire, then starts counting again. A T of 0 or 1 fires on every `trg1`.
- R9: Mode 7: `trg1` in cycle k opens a window. `trg2` in any of cycles k+1 to k+T closes it silently. Otherwise `fire` is 1 one clock after cycle k+T. `trg1` while a window is open is ignored, and a T of 0 acts as 1.
- R10: Every closed interval in modes 1 to 4 updates `extreme`. With `pick_min` at 0 the value becomes the larger of the old value and the new interval. With `pick_min` at 1 it becomes the smaller, and the first interval after enable is loaded as it is.
- R11: The interval counter stops at its all-ones value instead of wrapping, so a very long interval still compares and records as the maximum.
- R12: Mode codes 6 and 8 to 31 never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low clears all state |
| mode | input | 5 | Trigger mode code |
| thresh | input | TW (26) | Threshold T, in cycles or occurrences |
| pick_min | input | 1 | 0 records the longest interval, 1 the shortest |
| ev_a | input | 1 | Event A flag |
| ev_b | input | 1 | Event B flag |
| trg1 | input | 1 | Trigger1 flag |
| trg2 | input | 1 | Trigger2 flag |
| fire | output | 1 | Capture event pulse |
| extreme | output | TW (26) | Longest or shortest interval recorded |

## Verification
In the interval modes, the close of one measurement and the start of the next can land in the same cycle: a B ends the open interval while an A opens a new one. The bench drives A and B together in one cycle of an open measurement. It then sends a lone B later. This B fires only if the shared cycle started a new interval, and the extreme value must then equal the gap counted from the shared cycle. The same edge also carries the fire decision and the extreme update, and both are checked at the same sample point.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
  localparam int MW = 5;

  localparam logic [MW-1:0] MD_LEVEL    = 5'd0;
  localparam logic [MW-1:0] MD_LAST_GT  = 5'd1;
  localparam logic [MW-1:0] MD_LAST_LT  = 5'd2;
  localparam logic [MW-1:0] MD_FIRST_GT = 5'd3;
  localparam logic [MW-1:0] MD_FIRST_LT = 5'd4;
  localparam logic [MW-1:0] MD_COUNT    = 5'd5;
  localparam logic [MW-1:0] MD_MISS     = 5'd7;

  function automatic logic is_span(input logic [MW-1:0] m);
    return (m == MD_LAST_GT) || (m == MD_LAST_LT) ||
           (m == MD_FIRST_GT) || (m == MD_FIRST_LT);
  endfunction

  function automatic logic is_last(input logic [MW-1:0] m);
    return (m == MD_LAST_GT) || (m == MD_LAST_LT);
  endfunction

  function automatic logic is_greater(input logic [MW-1:0] m);
    return (m == MD_LAST_GT) || (m == MD_FIRST_GT);
  endfunction
endpackage

// File: rtl/ivl_span.sv
module ivl_span #(
  parameter int TW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart_on_a,
  input  logic          ev_a,
  input  logic          close,
  output logic          armed,
  output logic [TW-1:0] cnt
);
  localparam logic [TW-1:0] CMAX = {TW{1'b1}};
  localparam logic [TW-1:0] ONE  = TW'(1);

  logic          armed_q, armed_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!run) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else begin
      if (armed_q && (cnt_q != CMAX)) cnt_d = cnt_q + ONE;
      if (close) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end
      if (ev_a && (!armed_q || close || restart_on_a)) begin
        armed_d = 1'b1;
        cnt_d   = ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed = armed_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/ivl_extreme.sv
module ivl_extreme #(
  parameter int TW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pick_min,
  input  logic          load,
  input  logic [TW-1:0] value,
  output logic [TW-1:0] extreme
);
  logic          seen_q, seen_d;
  logic [TW-1:0] ext_q, ext_d;
  logic          better;

  always_comb begin
    better = pick_min ? (value < ext_q) : (value > ext_q);
    seen_d = seen_q;
    ext_d  = ext_q;
    if (!en) begin
      seen_d = 1'b0;
      ext_d  = '0;
    end else if (load) begin
      seen_d = 1'b1;
      if (!seen_q || better) ext_d = value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ext_q  <= '0;
    end else begin
      seen_q <= seen_d;
      ext_q  <= ext_d;
    end
  end

  assign extreme = ext_q;
endmodule

// File: rtl/ivl_tally.sv
module ivl_tally #(
  parameter int TW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_run,
  input  logic          miss_run,
  input  logic          trg1,
  input  logic          trg2,
  input  logic [TW-1:0] thresh,
  output logic          count_hit,
  output logic          miss_hit
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] occ_q, occ_d;
  logic [TW:0]   occ_inc;
  logic [TW-1:0] win_q, win_d;
  logic          wait_q, wait_d;

  always_comb begin
    occ_inc   = {1'b0, occ_q} + {{TW{1'b0}}, 1'b1};
    occ_d     = occ_q;
    count_hit = 1'b0;
    if (!count_run) begin
      occ_d = '0;
    end else if (trg1) begin
      if (occ_inc >= {1'b0, thresh}) begin
        count_hit = 1'b1;
        occ_d     = '0;
      end else begin
        occ_d = occ_inc[TW-1:0];
      end
    end
  end

  always_comb begin
    wait_d   = wait_q;
    win_d    = win_q;
    miss_hit = 1'b0;
    if (!miss_run) begin
      wait_d = 1'b0;
      win_d  = '0;
    end else if (wait_q) begin
      if (trg2) begin
        wait_d = 1'b0;
      end else if (win_q >= thresh) begin
        miss_hit = 1'b1;
        wait_d   = 1'b0;
      end else begin
        win_d = win_q + ONE;
      end
    end else if (trg1) begin
      wait_d = 1'b1;
      win_d  = ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      win_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      occ_q  <= occ_d;
      win_q  <= win_d;
      wait_q <= wait_d;
    end
  end
endmodule

// File: rtl/ivl_engine.sv
module ivl_engine
  import ivl_pkg::*;
#(
  parameter int TW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [MW-1:0] mode,
  input  logic [TW-1:0] thresh,
  input  logic          pick_min,
  input  logic          ev_a,
  input  logic          ev_b,
  input  logic          trg1,
  input  logic          trg2,
  output logic          fire,
  output logic [TW-1:0] extreme
);
  logic          span_run, span_close, span_armed, span_pass;
  logic [TW-1:0] span_cnt;
  logic          count_hit, miss_hit;
  logic          fire_q, fire_d;

  assign span_run   = en && is_span(mode);
  assign span_close = span_run && span_armed && ev_b;
  assign span_pass  = is_greater(mode) ? (span_cnt > thresh) : (span_cnt < thresh);

  ivl_span #(.TW(TW)) u_span (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (span_run),
    .restart_on_a (is_last(mode)),
    .ev_a         (ev_a),
    .close        (span_close),
    .armed        (span_armed),
    .cnt          (span_cnt)
  );

  ivl_extreme #(.TW(TW)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pick_min (pick_min),
    .load     (span_close),
    .value    (span_cnt),
    .extreme  (extreme)
  );

  ivl_tally #(.TW(TW)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_run (en && (mode == MD_COUNT)),
    .miss_run  (en && (mode == MD_MISS)),
    .trg1      (trg1),
    .trg2      (trg2),
    .thresh    (thresh),
    .count_hit (count_hit),
    .miss_hit  (miss_hit)
  );

  always_comb begin
    fire_d = 1'b0;
    if (en) begin
      case (mode)
        MD_LEVEL:    fire_d = trg1;
        MD_LAST_GT,
        MD_LAST_LT,
        MD_FIRST_GT,
        MD_FIRST_LT: fire_d = span_close && span_pass;
        MD_COUNT:    fire_d = count_hit;
        MD_MISS:     fire_d = miss_hit;
        default:     fire_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign fire = fire_q;
endmodule

// File: rtl/ivl_engine_chk.sv
module ivl_engine_chk
  import ivl_pkg::*;
#(
  parameter int TW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [MW-1:0] mode,
  input logic          pick_min,
  input logic          ev_a,
  input logic          ev_b,
  input logic          trg1,
  input logic          fire,
  input logic [TW-1:0] extreme,
  input logic          armed,
  input logic [TW-1:0] cnt
);
  logic quiet_mode;
  assign quiet_mode = (mode == 5'd6) || (mode >= 5'd8);

  // R1
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fire && (extreme == '0)));

  // R2
  level_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode == MD_LEVEL) && trg1) |=> fire);

  // R12
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && quiet_mode) |=> !fire);

  // R6
  lone_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_span(mode) && !armed && ev_b) |=> !fire);

  // R10
  max_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pick_min) |=> (extreme >= $past(extreme)));

  // R10
  min_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pick_min && (extreme != '0)) |=> (extreme <= $past(extreme)));

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_span(mode) && armed && (cnt == {TW{1'b1}}) && !ev_a && !ev_b)
      |=> (cnt == {TW{1'b1}}));
endmodule

bind ivl_engine ivl_engine_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .mode     (mode),
  .pick_min (pick_min),
  .ev_a     (ev_a),
  .ev_b     (ev_b),
  .trg1     (trg1),
  .fire     (fire),
  .extreme  (extreme),
  .armed    (span_armed),
  .cnt      (span_cnt)
);

// File: tb/sim_ivl_engine.sv
module sim_ivl_engine;
  localparam int CLK_NS = 10;
  localparam int TW     = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [4:0]    mode;
  logic [TW-1:0] thresh;
  logic          pick_min, ev_a, ev_b, trg1, trg2;
  logic          fire;
  logic [TW-1:0] extreme;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  ivl_engine #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .thresh(thresh),
    .pick_min(pick_min), .ev_a(ev_a), .ev_b(ev_b), .trg1(trg1), .trg2(trg2),
    .fire(fire), .extreme(extreme)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int m, input int t, input logic pm);
    en = 1'b0; ev_a = 0; ev_b = 0; trg1 = 0; trg2 = 0;
    tick();
    mode = 5'(m); thresh = TW'(t); pick_min = pm; en = 1'b1;
  endtask

  task automatic pair(input int gap);
    ev_a = 1; tick(); ev_a = 0;
    repeat (gap - 1) tick();
    ev_b = 1; tick(); ev_b = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset fire", fire, 0);
    chk("R1 reset extreme", extreme, 0);
  endtask

  task automatic t_level();
    setup(0, 0, 0);
    trg1 = 1; tick(); trg1 = 0;
    chk("R2 fire after trg1", fire, 1);
    tick();
    chk("R2 pulse ends", fire, 0);
    en = 0; trg1 = 1; tick(); trg1 = 0;
    chk("R1 disabled trg1", fire, 0);
  endtask

  task automatic t_last();
    setup(1, 5, 0);
    pair(6);
    chk("R3 gap6>5 fires", fire, 1);
    pair(5);
    chk("R6 gap equal T silent", fire, 0);
    ev_a = 1; tick(); ev_a = 0; repeat (3) tick();
    ev_a = 1; tick(); ev_a = 0; repeat (3) tick();
    ev_b = 1; tick(); ev_b = 0;
    chk("R3 restart gives 4, silent", fire, 0);
    setup(2, 5, 0);
    pair(3);
    chk("R4 gap3<5 fires", fire, 1);
    pair(5);
    chk("R6 mode2 equal silent", fire, 0);
  endtask

  task automatic t_first();
    setup(3, 5, 0);
    ev_a = 1; tick(); ev_a = 0; repeat (3) tick();
    ev_a = 1; tick(); ev_a = 0; repeat (3) tick();
    ev_b = 1; tick(); ev_b = 0;
    chk("R5 mode3 first A gives 8", fire, 1);
    chk("R10 extreme 8", extreme, 8);
    setup(4, 5, 0);
    ev_a = 1; tick(); ev_a = 0; repeat (3) tick();
    ev_a = 1; tick(); ev_a = 0; repeat (3) tick();
    ev_b = 1; tick(); ev_b = 0;
    chk("R5 mode4 later A ignored", fire, 0);
  endtask

  task automatic t_lone_b();
    setup(1, 0, 0);
    ev_b = 1; tick(); ev_b = 0;
    chk("R6 lone B", fire, 0);
    pair(2);
    chk("R6 normal pair fires", fire, 1);
    ev_b = 1; tick(); ev_b = 0;
    chk("R6 second B ignored", fire, 0);
    ev_a = 1; tick(); ev_a = 0;
    en = 0; tick(); en = 1;
    chk("R1 extreme cleared", extreme, 0);
    ev_b = 1; tick(); ev_b = 0;
    chk("R1 open A forgotten", fire, 0);
  endtask

  task automatic t_same_cycle();
    setup(1, 5, 0);
    ev_a = 1; tick(); ev_a = 0; tick();
    ev_a = 1; ev_b = 1; tick(); ev_a = 0; ev_b = 0;
    chk("R7 closed interval 2 silent", fire, 0);
    chk("R7 extreme 2", extreme, 2);
    repeat (6) tick();
    ev_b = 1; tick(); ev_b = 0;
    chk("R7 new interval 7 fires", fire, 1);
    chk("R7 extreme 7", extreme, 7);
  endtask

  task automatic t_extreme();
    setup(2, 0, 1);
    pair(4); chk("R10 min first load", extreme, 4);
    pair(9); chk("R10 min keeps 4", extreme, 4);
    pair(2); chk("R10 min takes 2", extreme, 2);
    setup(3, 1000, 0);
    chk("R1 extreme cleared by disable", extreme, 0);
    pair(4); chk("R10 max 4", extreme, 4);
    pair(9); chk("R10 max 9", extreme, 9);
    pair(2); chk("R10 max keeps 9", extreme, 9);
  endtask

  task automatic t_saturate();
    setup(1, 1022, 0);
    pair(1100);
    chk("R11 saturated > T fires", fire, 1);
    chk("R11 extreme all ones", extreme, 1023);
  endtask

  task automatic t_count();
    setup(5, 3, 0);
    for (int i = 1; i <= 6; i++) begin
      trg1 = 1; tick(); trg1 = 0;
      chk("R8 count fire", fire, (i % 3 == 0) ? 1 : 0);
      tick();
    end
    setup(5, 0, 0);
    trg1 = 1; tick(); trg1 = 0;
    chk("R8 T0 every trg1", fire, 1);
  endtask

  task automatic t_miss();
    setup(7, 4, 0);
    trg1 = 1; tick(); trg1 = 0;
    repeat (3) begin tick(); chk("R9 no early fire", fire, 0); end
    tick();
    chk("R9 fire at k+T", fire, 1);
    tick();
    chk("R9 single pulse", fire, 0);
    trg1 = 1; tick(); trg1 = 0;
    repeat (3) tick();
    trg2 = 1; tick(); trg2 = 0;
    chk("R9 trg2 at k+T cancels", fire, 0);
    repeat (3) tick();
    chk("R9 stays silent", fire, 0);
  endtask

  task automatic t_quiet();
    setup(6, 0, 0);
    trg1 = 1; tick(); trg1 = 0;
    chk("R12 mode6 silent", fire, 0);
    setup(9, 0, 0);
    trg1 = 1; tick(); trg1 = 0;
    pair(3);
    chk("R12 mode9 silent", fire, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; mode = 0; thresh = 0; pick_min = 0;
    ev_a = 0; ev_b = 0; trg1 = 0; trg2 = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_level();
    t_last();
    t_first();
    t_lone_b();
    t_same_cycle();
    t_extreme();
    t_saturate();
    t_count();
    t_miss();
    t_quiet();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule